// File: doc/BRIEF.md
# Halfword Prefetch Queue with IT Co-Issue

This block sits between a 32-bit instruction fetch port and the decode stage of a pipeline that runs a mixed 16/32-bit instruction encoding. Fetched words are split into halfwords and held in a small circular queue. Every cycle the queue offers the decoder its two oldest halfwords. It decides whether they form nothing, one 16-bit instruction, one 32-bit instruction, or a 16-bit instruction plus an if-then (IT) instruction issued in the same slot. In the last case the IT costs no decode cycle of its own. This is called folding.

The fetch side uses a level request. The block raises `fetch_req_o` while the queue has room for a whole word. A fetch completes in any cycle where the memory raises `fetch_valid_i` while the request is high. Holding `fetch_valid_i` low models wait states. A taken branch pulses `flush_i`, which empties the queue. `flush_odd_i` marks a branch target at the upper halfword of its fetch word, so the lower half of the first word fetched afterwards is dropped. The decoder always consumes what is issued. The queue pops as many halfwords as the issued instructions use.

Top module: `pfb_it_fold`

## Requirements
- R1: After reset the queue is empty. Nothing is issued (`dec_count_o` = 0, `dec_fold_o` = 0) and `fetch_req_o` is 1.
- R2: A fetch word is accepted when `fetch_req_o`, `fetch_valid_i` and not `flush_i` hold together. Bits [15:0] are the earlier halfword in program order and bits [31:16] the later one.
- R3: The queue holds 2×WORDS halfwords (six by default). `fetch_req_o` is 1 exactly when at least two slots are free, so the fill never exceeds capacity.
- R4: A halfword whose bits [15:11] are 11101, 11110 or 11111 starts a 32-bit instruction. It is issued only when the following halfword is also held. It then gives `dec_count_o` = 1 and `dec_is32_o` = 1, `dec_instr_o` = {first, second}, and pops two halfwords. While the second half is missing, nothing is issued.
- R5: Any other head halfword is a 16-bit instruction. It is issued alone with `dec_count_o` = 1, `dec_instr_o` = {16'h0000, halfword}, and pops one halfword.
- R6: An IT instruction is the halfword 8'hBF in bits [15:8] with a nonzero value in bits [3:0]. With bits [3:0] zero the halfword is a hint and is never folded.
- R7: If the head is a 16-bit instruction that is neither a branch nor an IT, and the next halfword is an IT, both issue together. Then `dec_count_o` = 2, `dec_fold_o` = 1, `dec_it_o` = the IT halfword, and two halfwords are popped.
- R8: These 16-bit heads count as branches and block folding: bits [15:12] = 4'hD with bits [11:9] ≠ 3'b111; bits [15:11] = 5'b11100; bits [15:8] = 8'h47; bits [15:12] = 4'hB with bit 10 = 0 and bit 8 = 1; bits [15:8] = 8'hBD.
- R9: If the IT halfword is not yet in the queue when its predecessor issues, no fold happens. The IT is later issued on its own.
- R10: Folding has no alignment requirement. The predecessor and the IT may sit at either halfword of their fetch words, including across two words.
- R11: During a `flush_i` cycle nothing is issued and fetch data is discarded. In the following cycle the queue is empty.
- R12: After a flush with `flush_odd_i` = 1, the first accepted word contributes only its bits [31:16].
- R13: `dec_it_o` is zero whenever `dec_fold_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Taken branch: empty the queue |
| flush_odd_i | input | 1 | Branch target is the upper halfword of its word |
| fetch_req_o | output | 1 | Queue has room for a whole fetch word |
| fetch_valid_i | input | 1 | Fetch data present this cycle |
| fetch_data_i | input | 32 | Fetched word, earlier halfword in [15:0] |
| dec_count_o | output | 2 | Instructions issued this cycle (0, 1 or 2) |
| dec_fold_o | output | 1 | An IT is co-issued with the head instruction |
| dec_is32_o | output | 1 | The head instruction is 32 bits wide |
| dec_instr_o | output | 32 | Head instruction bits |
| dec_it_o | output | 16 | Co-issued IT halfword, zero otherwise |

## Verification
The bench builds the block with its default parameters: three words of storage (six halfword slots) and folding enabled. With only six slots, a steady stream of single-issue 16-bit instructions fills the queue to five within four fetches. That makes the point where the request drops, and where it returns, quick to reach. The enabled fold path lets the table cover every branch class and hint case that must block a fold. The odd-target flush lets directed tests place a 32-bit prefix or an IT alone at the queue head, so the wait-for-second-half and late-IT cases can be observed.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

   localparam int HALF_W = 16;

   typedef logic [HALF_W-1:0] half_t;

   typedef enum logic [1:0] {
      ISS_NONE  = 2'd0,
      ISS_SHORT = 2'd1,
      ISS_WIDE  = 2'd2,
      ISS_FOLD  = 2'd3
   } issue_kind_e;

   // first half of a 32-bit encoding
   function automatic logic is_wide(input half_t h);
      return (h[15:11] == 5'b11101) || (h[15:11] == 5'b11110) ||
             (h[15:11] == 5'b11111);
   endfunction

   // if-then with a nonzero mask; a zero mask is a hint
   function automatic logic is_ifthen(input half_t h);
      return (h[15:8] == 8'hBF) && (h[3:0] != 4'h0);
   endfunction

   // 16-bit encodings that change the flow of control
   function automatic logic is_branch16(input half_t h);
      logic cond_b, uncond_b, reg_b, cmp_b, pop_pc;
      cond_b   = (h[15:12] == 4'hD) && (h[11:9] != 3'b111);
      uncond_b = (h[15:11] == 5'b11100);
      reg_b    = (h[15:8] == 8'h47);
      cmp_b    = (h[15:12] == 4'hB) && !h[10] && h[8];
      pop_pc   = (h[15:8] == 8'hBD);
      return cond_b || uncond_b || reg_b || cmp_b || pop_pc;
   endfunction

endpackage

// File: rtl/pfb_fetch.sv
module pfb_fetch
   import pfb_pkg::*;
#(
   parameter int SLOTS = 6,
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             flush_odd,
   input  logic [LVL_W-1:0] level,
   input  logic             fetch_valid,
   input  logic [31:0]      fetch_data,
   output logic             fetch_req,
   output logic [1:0]       push_n,
   output half_t            push_first,
   output half_t            push_second
);

   localparam logic [LVL_W-1:0] ROOM_LIMIT = LVL_W'(SLOTS - 2);

   logic drop_q;
   logic accept;

   assign fetch_req = (level <= ROOM_LIMIT);
   assign accept    = fetch_req && fetch_valid && !flush;

   always_ff @(posedge clk) begin
      if (!rst_n)
         drop_q <= 1'b0;
      else if (flush)
         drop_q <= flush_odd;
      else if (accept)
         drop_q <= 1'b0;
   end

   always_comb begin
      push_n      = 2'd0;
      push_first  = fetch_data[15:0];
      push_second = fetch_data[31:16];
      if (accept) begin
         if (drop_q) begin
            push_n     = 2'd1;
            push_first = fetch_data[31:16];
         end else begin
            push_n = 2'd2;
         end
      end
   end

endmodule

// File: rtl/pfb_queue.sv
module pfb_queue
   import pfb_pkg::*;
#(
   parameter int SLOTS = 6,
   parameter int PTR_W = 3,
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [1:0]       push_n,
   input  half_t            push_first,
   input  half_t            push_second,
   input  logic [1:0]       pop_n,
   output half_t            head0,
   output half_t            head1,
   output logic [LVL_W-1:0] level
);

   localparam int SUM_W = LVL_W + 1;

   function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] b,
                                                 input logic [LVL_W-1:0] inc);
      logic [SUM_W-1:0] s;
      s = SUM_W'(b) + SUM_W'(inc);
      if (s >= SUM_W'(SLOTS))
         s = s - SUM_W'(SLOTS);
      return s[PTR_W-1:0];
   endfunction

   logic [PTR_W-1:0] head_q;
   logic [LVL_W-1:0] level_q;
   logic [PTR_W-1:0] tail0, tail1, head_nx1;
   half_t            slots_w [SLOTS];

   assign tail0    = wrap_add(head_q, level_q);
   assign tail1    = wrap_add(head_q, level_q + LVL_W'(1));
   assign head_nx1 = wrap_add(head_q, LVL_W'(1));

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      half_t slot_q;
      logic  wr_first, wr_second;
      assign wr_first  = (push_n != 2'd0) && (tail0 == PTR_W'(s));
      assign wr_second = (push_n == 2'd2) && (tail1 == PTR_W'(s));
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q <= '0;
         else if (wr_first)
            slot_q <= push_first;
         else if (wr_second)
            slot_q <= push_second;
      end
      assign slots_w[s] = slot_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         head_q  <= '0;
         level_q <= '0;
      end else begin
         head_q  <= wrap_add(head_q, LVL_W'(pop_n));
         level_q <= level_q - LVL_W'(pop_n) + LVL_W'(push_n);
      end
   end

   assign head0 = slots_w[head_q];
   assign head1 = slots_w[head_nx1];
   assign level = level_q;

endmodule

// File: rtl/pfb_issue.sv
module pfb_issue
   import pfb_pkg::*;
#(
   parameter bit FOLD_EN = 1'b1,
   parameter int LVL_W   = 3
) (
   input  logic             kill,
   input  half_t            head0,
   input  half_t            head1,
   input  logic [LVL_W-1:0] level,
   output logic [1:0]       count,
   output logic             fold,
   output logic             is32,
   output logic [31:0]      instr,
   output half_t            it_half,
   output logic [1:0]       pop_n
);

   logic        have1, have2, wide, fold_ok;
   issue_kind_e kind;

   assign have1 = (level != '0);
   assign have2 = (level >= LVL_W'(2));
   assign wide  = is_wide(head0);

   if (FOLD_EN) begin : g_fold
      assign fold_ok = have2 && !wide && !is_branch16(head0) &&
                       !is_ifthen(head0) && is_ifthen(head1);
   end else begin : g_nofold
      assign fold_ok = 1'b0;
   end

   always_comb begin
      if (kill || !have1)
         kind = ISS_NONE;
      else if (wide)
         kind = have2 ? ISS_WIDE : ISS_NONE;
      else if (fold_ok)
         kind = ISS_FOLD;
      else
         kind = ISS_SHORT;
   end

   always_comb begin
      count   = 2'd0;
      fold    = 1'b0;
      is32    = 1'b0;
      instr   = '0;
      it_half = '0;
      pop_n   = 2'd0;
      unique case (kind)
         ISS_SHORT: begin
            count = 2'd1;
            instr = {16'h0000, head0};
            pop_n = 2'd1;
         end
         ISS_WIDE: begin
            count = 2'd1;
            is32  = 1'b1;
            instr = {head0, head1};
            pop_n = 2'd2;
         end
         ISS_FOLD: begin
            count   = 2'd2;
            fold    = 1'b1;
            instr   = {16'h0000, head0};
            it_half = head1;
            pop_n   = 2'd2;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pfb_it_fold.sv
module pfb_it_fold
   import pfb_pkg::*;
#(
   parameter int WORDS   = 3,
   parameter bit FOLD_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        flush_i,
   input  logic        flush_odd_i,
   output logic        fetch_req_o,
   input  logic        fetch_valid_i,
   input  logic [31:0] fetch_data_i,
   output logic [1:0]  dec_count_o,
   output logic        dec_fold_o,
   output logic        dec_is32_o,
   output logic [31:0] dec_instr_o,
   output logic [15:0] dec_it_o
);

   localparam int SLOTS = 2 * WORDS;
   localparam int PTR_W = $clog2(SLOTS);
   localparam int LVL_W = $clog2(SLOTS + 1);

   if (WORDS < 2) begin : g_bad_depth
      $error("pfb_it_fold: WORDS must be at least 2");
   end

   logic [LVL_W-1:0] level;
   logic [1:0]       push_n, pop_n;
   half_t            push_first, push_second, head0, head1;

   pfb_fetch #(.SLOTS(SLOTS), .LVL_W(LVL_W)) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush_i),
      .flush_odd   (flush_odd_i),
      .level       (level),
      .fetch_valid (fetch_valid_i),
      .fetch_data  (fetch_data_i),
      .fetch_req   (fetch_req_o),
      .push_n      (push_n),
      .push_first  (push_first),
      .push_second (push_second)
   );

   pfb_queue #(.SLOTS(SLOTS), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_queue (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush_i),
      .push_n      (push_n),
      .push_first  (push_first),
      .push_second (push_second),
      .pop_n       (pop_n),
      .head0       (head0),
      .head1       (head1),
      .level       (level)
   );

   pfb_issue #(.FOLD_EN(FOLD_EN), .LVL_W(LVL_W)) u_issue (
      .kill    (flush_i),
      .head0   (head0),
      .head1   (head1),
      .level   (level),
      .count   (dec_count_o),
      .fold    (dec_fold_o),
      .is32    (dec_is32_o),
      .instr   (dec_instr_o),
      .it_half (dec_it_o),
      .pop_n   (pop_n)
   );

endmodule

// File: rtl/pfb_it_fold_chk.sv
module pfb_it_fold_chk #(
   parameter int SLOTS = 6,
   parameter int LVL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush_i,
   input logic             fetch_req_o,
   input logic [1:0]       dec_count_o,
   input logic             dec_fold_o,
   input logic             dec_is32_o,
   input logic [15:0]      dec_it_o,
   input logic [LVL_W-1:0] level
);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(SLOTS));

   assert_req_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req_o |-> (level <= LVL_W'(SLOTS - 2)));

   assert_flush_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (level == '0));

   assert_flush_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |-> (dec_count_o == 2'd0));

   assert_fold_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_fold_o |-> (dec_count_o == 2'd2) && !dec_is32_o);

   assert_fold_it_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dec_fold_o |-> (dec_it_o[15:8] == 8'hBF) && (dec_it_o[3:0] != 4'h0));

   assert_it_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_fold_o |-> (dec_it_o == 16'h0000));

   assert_wide_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dec_is32_o |-> (dec_count_o == 2'd1));

endmodule

bind pfb_it_fold pfb_it_fold_chk #(.SLOTS(SLOTS), .LVL_W(LVL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush_i     (flush_i),
   .fetch_req_o (fetch_req_o),
   .dec_count_o (dec_count_o),
   .dec_fold_o  (dec_fold_o),
   .dec_is32_o  (dec_is32_o),
   .dec_it_o    (dec_it_o),
   .level       (level)
);

// File: tb/pfb_it_fold_bench.sv
`timescale 1ns/1ps
module pfb_it_fold_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush_i = 1'b0, flush_odd_i = 1'b0;
   logic        fetch_valid_i = 1'b0;
   logic [31:0] fetch_data_i = '0;
   logic        fetch_req_o, dec_fold_o, dec_is32_o;
   logic [1:0]  dec_count_o;
   logic [31:0] dec_instr_o;
   logic [15:0] dec_it_o;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   pfb_it_fold u_pfb_it_fold (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_odd_i(flush_odd_i),
      .fetch_req_o(fetch_req_o), .fetch_valid_i(fetch_valid_i),
      .fetch_data_i(fetch_data_i), .dec_count_o(dec_count_o),
      .dec_fold_o(dec_fold_o), .dec_is32_o(dec_is32_o),
      .dec_instr_o(dec_instr_o), .dec_it_o(dec_it_o)
   );

   // word, count, fold, is32, instr, it
   localparam int NV = 12;
   localparam logic [83:0] VEC [NV] = '{
      {32'hBF08_2800, 2'd2, 1'b1, 1'b0, 32'h0000_2800, 16'hBF08}, // R7 compare + IT
      {32'hBF00_2800, 2'd1, 1'b0, 1'b0, 32'h0000_2800, 16'h0000}, // R6 hint, no fold
      {32'hBF08_D001, 2'd1, 1'b0, 1'b0, 32'h0000_D001, 16'h0000}, // R8 cond branch
      {32'hBF08_4770, 2'd1, 1'b0, 1'b0, 32'h0000_4770, 16'h0000}, // R8 register branch
      {32'hF800_F000, 2'd1, 1'b0, 1'b1, 32'hF000_F800, 16'h0000}, // R4 wide pair
      {32'hBF18_B100, 2'd1, 1'b0, 1'b0, 32'h0000_B100, 16'h0000}, // R8 compare-branch
      {32'hBF18_BD00, 2'd1, 1'b0, 1'b0, 32'h0000_BD00, 16'h0000}, // R8 pop to pc
      {32'hBF18_BF08, 2'd1, 1'b0, 1'b0, 32'h0000_BF08, 16'h0000}, // R7 IT head not folded
      {32'h4608_2800, 2'd1, 1'b0, 1'b0, 32'h0000_2800, 16'h0000}, // R5 plain 16-bit
      {32'hBF04_1840, 2'd2, 1'b1, 1'b0, 32'h0000_1840, 16'hBF04}, // R7 add + IT
      {32'hBF18_E7FE, 2'd1, 1'b0, 1'b0, 32'h0000_E7FE, 16'h0000}, // R8 16-bit jump
      {32'hBF18_E92D, 2'd1, 1'b0, 1'b1, 32'hE92D_BF18, 16'h0000}  // R4 wide 11101
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_flush(input logic odd);
      flush_i = 1'b1; flush_odd_i = odd; fetch_valid_i = 1'b0;
      tick();
      flush_i = 1'b0; flush_odd_i = 1'b0;
   endtask

   task automatic push_word(input logic [31:0] w);
      fetch_valid_i = 1'b1; fetch_data_i = w;
      tick();
      fetch_valid_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      check("R1 count", 32'(dec_count_o), 0);
      check("R1 fold", 32'(dec_fold_o), 0);
      check("R1 req", 32'(fetch_req_o), 1);

      // table walk: R2 R4 R5 R6 R7 R8 R13
      for (int i = 0; i < NV; i++) begin
         do_flush(1'b0);
         push_word(VEC[i][83:52]);
         check($sformatf("table %0d R2/R5 count", i), 32'(dec_count_o), 32'(VEC[i][51:50]));
         check($sformatf("table %0d R7 fold", i), 32'(dec_fold_o), 32'(VEC[i][49]));
         check($sformatf("table %0d R4 is32", i), 32'(dec_is32_o), 32'(VEC[i][48]));
         check($sformatf("table %0d R2 instr", i), dec_instr_o, VEC[i][47:16]);
         check($sformatf("table %0d R13 it", i), 32'(dec_it_o), 32'(VEC[i][15:0]));
         repeat (3) tick();
      end

      // R9 + R12: compare arrives alone, IT follows one fetch later
      do_flush(1'b1);
      push_word(32'h2800_1234);
      check("R12 odd head", dec_instr_o, 32'h0000_2800);
      check("R9 no early fold", 32'(dec_fold_o), 0);
      push_word(32'h4608_BF08);
      check("R9 IT alone count", 32'(dec_count_o), 1);
      check("R9 IT alone instr", dec_instr_o, 32'h0000_BF08);
      check("R9 IT alone fold", 32'(dec_fold_o), 0);
      repeat (3) tick();

      // R10: predecessor at upper half, IT at lower half of the next word
      do_flush(1'b0);
      push_word(32'h2800_4608);
      check("R10 first issue", dec_instr_o, 32'h0000_4608);
      push_word(32'h1111_BF08);
      check("R10 fold across words", 32'(dec_fold_o), 1);
      check("R10 fold it", 32'(dec_it_o), 32'h0000_BF08);
      check("R10 fold head", dec_instr_o, 32'h0000_2800);
      repeat (3) tick();

      // R4: wide prefix waits for its second half
      do_flush(1'b1);
      push_word(32'hF000_1111);
      check("R4 half wide waits", 32'(dec_count_o), 0);
      push_word(32'h2800_F800);
      check("R4 wide complete", 32'(dec_is32_o), 1);
      check("R4 wide instr", dec_instr_o, 32'hF000_F800);
      repeat (4) tick();

      // R3: fill until request drops, then returns
      do_flush(1'b0);
      fetch_valid_i = 1'b1; fetch_data_i = 32'h4608_4608;
      tick(); tick(); tick();
      check("R3 req at level 4", 32'(fetch_req_o), 1);
      tick();
      check("R3 req low at level 5", 32'(fetch_req_o), 0);
      tick();
      check("R3 req back at level 4", 32'(fetch_req_o), 1);
      fetch_valid_i = 1'b0;

      // R11: flush while data arrives
      fetch_valid_i = 1'b1; fetch_data_i = 32'hBF08_2800; flush_i = 1'b1;
      #1;
      check("R11 no issue in flush", 32'(dec_count_o), 0);
      tick();
      flush_i = 1'b0; fetch_valid_i = 1'b0;
      check("R11 empty after flush", 32'(dec_count_o), 0);
      tick();
      check("R11 data discarded", 32'(dec_count_o), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule